// File: doc/BRIEF.md
# Piecewise Gamma Code-to-Level Interpolator

This block turns 6-bit pixel codes into target drive levels for a row of display columns. Each column holds a code and a polarity bit. The polarity bit selects one of two sets of seven reference levels. Fourteen reference words stand in for external gamma reference voltages.

- The upper set (indices 0 to 6) covers the range from mid-supply upward.
- The lower set (indices 7 to 13) covers the range from mid-supply downward.

Seven codes, 0, 1, 16, 32, 48, 62 and 63, land exactly on a reference. Codes between two of these breakpoints are interpolated linearly between the two adjacent references and rounded to the nearest step, in the way a resistor ladder divides the gap. The two polarities run the curve in opposite directions from opposite ends of the range.

A start pulse begins a pass over the columns. The block drives a column index to a memory that has one cycle of read latency. It takes back the code and polarity, and writes one level word per column per clock through a write port. A single-cycle done flag follows the last write.

Top module: `gamma_interp_top`

## Requirements
- R1: While reset is low, and in the first cycle after it, `wr_en` and `done` are 0. `rd_addr` is 0 after reset.
- R2: A start sampled while idle drives `rd_addr` through 0, 1, …, NCOL-1, one step per clock. `rd_addr` equals k in the k-th cycle after the start edge.
- R3: The memory returns the data for `rd_addr` one clock later. The write for column i appears two clocks after `rd_addr` shows i, with `wr_addr` = i. Writes come in consecutive cycles.
- R4: `done` is high for exactly one cycle, in the cycle after the write of column NCOL-1.
- R5: A start sampled while a pass is reading is ignored. The address sequence, the write count and the single done pulse are unchanged.
- R6: With `rd_pol` = 1, codes 0, 1, 16, 32, 48, 62 and 63 give exactly references 0, 1, 2, 3, 4, 5 and 6. Reference k occupies `ref_lvls[k*LVL_W +: LVL_W]`.
- R7: With `rd_pol` = 0, codes 0, 1, 16, 32, 48, 62 and 63 give exactly references 13, 12, 11, 10, 9, 8 and 7.
- R8: A code c in a segment that starts at breakpoint b, with span S (1, 15, 16, 16, 14 and 1 codes), gives a level computed from its two end references. A is the reference at b and B is the reference at the next breakpoint. The level is A ± floor((2·|B−A|·(c−b) + S) / (2·S)), with the sign toward B.
- R9: Every level lies between the two references that bound its segment.
- R10: When the references meet the ordering rules, the output is non-increasing in code for polarity 1. It is non-decreasing in code for polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a pass over all columns when idle |
| rd_addr | output | COL_W | Column index presented to the code memory |
| rd_code | input | 6 | Pixel code of the column read one cycle earlier |
| rd_pol | input | 1 | Polarity of that column (1 = upper set) |
| ref_lvls | input | 14*LVL_W | Fourteen reference words, index k at bits k*LVL_W |
| wr_en | output | 1 | Level write strobe |
| wr_addr | output | COL_W | Column of the level being written |
| wr_level | output | LVL_W | Interpolated level |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The start edge is taken as cycle 0. `rd_addr` must read k at cycle k, the write of column k is due at cycle k+2, and `done` is due only at cycle NCOL+2. The bench counts negative clock edges from the start edge and samples every output at each one. It therefore checks both that each result appears in its due cycle and that nothing appears in any other cycle. Level values come from the arithmetic of R8, evaluated in the bench for ascending code sweeps in each polarity and for a scrambled code and polarity pattern. A repeated start is injected in the middle of one pass.

// File: rtl/gamma_interp_pkg.sv
// Shared constants for the gamma interpolator: breakpoint codes and
// field types. Assumes 6-bit codes and fourteen references.
package gamma_interp_pkg;
    localparam int NREF    = 14;
    localparam int CODE_W  = 6;
    typedef logic [2:0] seg_t;   // segment 0..5
    typedef logic [4:0] span_t;  // codes in a segment: 1, 14, 15 or 16
    typedef logic [4:0] off_t;   // code minus segment start
    localparam logic [CODE_W-1:0] BP1 = 6'd1;
    localparam logic [CODE_W-1:0] BP2 = 6'd16;
    localparam logic [CODE_W-1:0] BP3 = 6'd32;
    localparam logic [CODE_W-1:0] BP4 = 6'd48;
    localparam logic [CODE_W-1:0] BP5 = 6'd62;
endpackage

// File: rtl/gi_seg_decode.sv
// Maps a 6-bit code onto its interpolation segment, its offset from the
// segment start and the segment span. Purely combinational; code 63 is
// expressed as offset 1 in the last unit-span segment.
module gi_seg_decode
    import gamma_interp_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output seg_t              seg,
    output off_t              off,
    output span_t             span
);
    // select the segment by comparing against the breakpoints
    always_comb begin
        if (code < BP1) begin
            seg = 3'd0; off = 5'd0;                    span = 5'd1;
        end else if (code < BP2) begin
            seg = 3'd1; off = 5'(code - BP1);          span = 5'd15;
        end else if (code < BP3) begin
            seg = 3'd2; off = 5'(code - BP2);          span = 5'd16;
        end else if (code < BP4) begin
            seg = 3'd3; off = 5'(code - BP3);          span = 5'd16;
        end else if (code < BP5) begin
            seg = 3'd4; off = 5'(code - BP4);          span = 5'd14;
        end else begin
            seg = 3'd5; off = 5'(code - BP5);          span = 5'd1;
        end
    end
endmodule

// File: rtl/gi_lerp.sv
// Picks the two end references of a segment for the given polarity and
// interpolates linearly with round-to-nearest (half rounds away from the
// start reference). Assumes span is 1, 14, 15 or 16.
module gi_lerp
    import gamma_interp_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chk_en,
    input  seg_t                  seg,
    input  off_t                  off,
    input  span_t                 span,
    input  logic                  pol,
    input  logic [NREF*LVL_W-1:0] ref_lvls,
    output logic [LVL_W-1:0]      level
);
    localparam int PW = LVL_W + 5;
    localparam int NW = PW + 2;

    logic [LVL_W-1:0] lvl [NREF];
    logic [3:0]       idx_a, idx_b;
    logic [LVL_W-1:0] end_a, end_b, mag;
    logic             toward_up;
    logic [PW-1:0]    prod;
    logic [NW-1:0]    num, quo;
    logic [LVL_W-1:0] step;

    // unpack the flat reference bus into words
    for (genvar k = 0; k < NREF; k++) begin : g_unpack
        assign lvl[k] = ref_lvls[k*LVL_W +: LVL_W];
    end

    // choose segment end references: upper set ascends index, lower descends
    always_comb begin
        idx_a = pol ? 4'(seg)        : 4'(4'd13 - 4'(seg));
        idx_b = pol ? 4'(4'(seg) + 4'd1) : 4'(4'd12 - 4'(seg));
        end_a = lvl[idx_a];
        end_b = lvl[idx_b];
    end

    // magnitude of the gap, scaled by offset, divided by span with rounding
    always_comb begin
        toward_up = (end_b >= end_a);
        mag       = toward_up ? (end_b - end_a) : (end_a - end_b);
        prod      = PW'(mag) * PW'(off);
        num       = {1'b0, prod, 1'b0} + NW'(span);
        case (span)
            5'd14:   quo = num / NW'(28);
            5'd15:   quo = num / NW'(30);
            5'd16:   quo = num / NW'(32);
            default: quo = num / NW'(2);
        endcase
        step  = LVL_W'(quo);
        level = toward_up ? (end_a + step) : (end_a - step);
    end

    // R9: interpolated level never leaves its segment
    p_within_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> ((end_b >= end_a) ? (level >= end_a && level <= end_b)
                                     : (level <= end_a && level >= end_b)));
endmodule

// File: rtl/gi_col_seq.sv
// Column sequencer: on a start while idle walks the read index over all
// columns one per clock, and flags the cycle in which each column's read
// data is returned (memory assumed to have one cycle of read latency).
module gi_col_seq #(
    parameter int NCOL  = 64,
    parameter int COL_W = $clog2(NCOL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [COL_W-1:0] rd_addr,
    output logic             data_vld,
    output logic [COL_W-1:0] data_col
);
    localparam logic [COL_W-1:0] LAST = COL_W'(NCOL - 1);
    logic busy;

    // read index walk; a start during a walk is not looked at
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rd_addr <= '0;
        end else if (!busy) begin
            busy    <= start;
            rd_addr <= '0;
        end else if (rd_addr == LAST) begin
            busy    <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_addr <= rd_addr + 1'b1;
        end
    end

    // mark the cycle in which memory data belongs to the issued index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_vld <= 1'b0;
            data_col <= '0;
        end else begin
            data_vld <= busy;
            data_col <= rd_addr;
        end
    end

    // R2: the index advances by one every clock of a walk
    p_index_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rd_addr != LAST |=> busy && rd_addr == $past(rd_addr) + 1'b1);

    // R5: a start during a walk does not send the index back to zero
    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && rd_addr != LAST |=> rd_addr != '0);
endmodule

// File: rtl/gamma_interp_top.sv
// Gamma code-to-level interpolator. Reads code and polarity per column,
// interpolates the level from fourteen references and writes it two
// clocks after the column index was issued. Assumes a read memory with
// one cycle of latency and references obeying the ordering rules.
module gamma_interp_top
    import gamma_interp_pkg::*;
#(
    parameter int NCOL  = 64,
    parameter int LVL_W = 10,
    parameter int COL_W = $clog2(NCOL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic [COL_W-1:0]      rd_addr,
    input  logic [CODE_W-1:0]     rd_code,
    input  logic                  rd_pol,
    input  logic [NREF*LVL_W-1:0] ref_lvls,
    output logic                  wr_en,
    output logic [COL_W-1:0]      wr_addr,
    output logic [LVL_W-1:0]      wr_level,
    output logic                  done
);
    localparam logic [COL_W-1:0] LAST = COL_W'(NCOL - 1);

    logic             data_vld;
    logic [COL_W-1:0] data_col;
    seg_t             seg;
    off_t             off;
    span_t            span;
    logic [LVL_W-1:0] level;

    gi_col_seq #(.NCOL(NCOL), .COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
        .data_vld(data_vld), .data_col(data_col)
    );

    gi_seg_decode u_dec (
        .code(rd_code), .seg(seg), .off(off), .span(span)
    );

    gi_lerp #(.LVL_W(LVL_W)) u_lerp (
        .clk(clk), .rst_n(rst_n), .chk_en(data_vld), .seg(seg), .off(off),
        .span(span), .pol(rd_pol), .ref_lvls(ref_lvls), .level(level)
    );

    // register the write port from the returned column data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_level <= '0;
        end else begin
            wr_en    <= data_vld;
            wr_addr  <= data_col;
            wr_level <= level;
        end
    end

    // one-cycle completion pulse after the last column's write
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= wr_en && (wr_addr == LAST);
    end

    // R1: reset leaves the write port and done quiet
    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !wr_en && !done);

    // R3: returned data produces a write for the same column next cycle
    p_write_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |=> wr_en && wr_addr == $past(data_col));

    // R4: done lasts one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done only after the last column was written
    p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en) && $past(wr_addr) == LAST);
endmodule

// File: tb/sim_gamma_interp_top.sv
// Sweeps codes over both polarities and two reference sets, checking
// every output in its due cycle against arithmetic from the requirements.
module sim_gamma_interp_top;
    localparam int NCOL = 64;
    localparam int LVL_W = 10;
    localparam int COL_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [COL_W-1:0] rd_addr;
    logic [5:0] rd_code;
    logic rd_pol;
    logic [14*LVL_W-1:0] ref_lvls;
    logic wr_en, done;
    logic [COL_W-1:0] wr_addr;
    logic [LVL_W-1:0] wr_level;

    int total = 0;
    int bad = 0;
    int rf [14];
    logic [5:0] code_mem [NCOL];
    logic pol_mem [NCOL];
    int got [NCOL];

    always #4 clk = ~clk;

    gamma_interp_top #(.NCOL(NCOL), .LVL_W(LVL_W), .COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
        .rd_code(rd_code), .rd_pol(rd_pol), .ref_lvls(ref_lvls),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_level(wr_level), .done(done)
    );

    // code memory with one cycle of read latency
    always_ff @(posedge clk) begin
        rd_code <= code_mem[rd_addr];
        rd_pol  <= pol_mem[rd_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_lvl(input int code, input bit pol);
        int bp [7] = '{0, 1, 16, 32, 48, 62, 63};
        int s = 0, off, span, a, b, mag, q;
        for (int k = 0; k < 6; k++) if (code >= bp[k]) s = k;
        off = code - bp[s];
        span = bp[s+1] - bp[s];
        a = pol ? rf[s] : rf[13-s];
        b = pol ? rf[s+1] : rf[12-s];
        mag = (b >= a) ? b - a : a - b;
        q = (2*mag*off + span) / (2*span);
        return (b >= a) ? a + q : a - q;
    endfunction

    task automatic load_refs(input int sel);
        int up1 [7] = '{1020, 1010, 900, 760, 600, 530, 515};
        int lo1 [7] = '{500, 480, 350, 220, 90, 12, 3};
        int up2 [7] = '{1023, 1023, 900, 900, 700, 600, 512};
        int lo2 [7] = '{511, 300, 300, 100, 50, 0, 0};
        for (int k = 0; k < 7; k++) begin
            rf[k]   = sel == 0 ? up1[k] : up2[k];
            rf[k+7] = sel == 0 ? lo1[k] : lo2[k];
        end
        for (int k = 0; k < 14; k++) ref_lvls[k*LVL_W +: LVL_W] = LVL_W'(rf[k]);
    endtask

    // mode 0: ascending codes pol 1; 1: ascending pol 0; 2: scrambled + restart
    task automatic run_pass(input int mode);
        int dones = 0, writes = 0;
        for (int c = 0; c < NCOL; c++) begin
            code_mem[c] = mode == 2 ? 6'((c*37 + 11) % 64) : 6'(c);
            pol_mem[c]  = mode == 2 ? ((c*5) % 3 == 0) : (mode == 0);
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < NCOL + 5; k++) begin
            // now in cycle k after the start edge
            if (k < NCOL) chk(rd_addr == COL_W'(k), "R2 rd_addr", int'(rd_addr), k);
            if (mode == 2 && k == 9) start = 1'b1;
            if (mode == 2 && k == 10) start = 1'b0;
            chk(wr_en == (k >= 2 && k < NCOL + 2), "R3 wr_en timing", int'(wr_en), int'(k >= 2 && k < NCOL + 2));
            chk(done == (k == NCOL + 2), "R4 done timing", int'(done), int'(k == NCOL + 2));
            if (done) dones++;
            if (wr_en && k >= 2 && k < NCOL + 2) begin
                int col = k - 2;
                int e = exp_lvl(int'(code_mem[col]), pol_mem[col]);
                writes++;
                chk(wr_addr == COL_W'(col), "R3 wr_addr", int'(wr_addr), col);
                got[col] = int'(wr_level);
                if (code_mem[col] inside {0, 1, 16, 32, 48, 62, 63})
                    chk(got[col] == e, pol_mem[col] ? "R6 breakpoint" : "R7 breakpoint", got[col], e);
                else
                    chk(got[col] == e, "R8 interpolation", got[col], e);
            end
            @(negedge clk);
        end
        chk(writes == NCOL, "R5 write count", writes, NCOL);
        chk(dones == 1, "R5 done count", dones, 1);
        if (mode != 2) begin
            for (int c = 1; c < NCOL; c++) begin
                // R10: upper set falls with code, lower set rises
                if (mode == 0) chk(got[c] <= got[c-1], "R10 monotonic pol1", got[c], got[c-1]);
                else           chk(got[c] >= got[c-1], "R10 monotonic pol0", got[c], got[c-1]);
            end
        end
        for (int c = 0; c < NCOL; c++) begin
            // R9: level between the bounding references of its segment
            int lo = exp_lvl(int'(code_mem[c]) < 62 ? 0 : 0, 1'b0);
            int s = 0, a, b;
            int bp [7] = '{0, 1, 16, 32, 48, 62, 63};
            lo = 0;
            for (int k = 0; k < 6; k++) if (int'(code_mem[c]) >= bp[k]) s = k;
            a = pol_mem[c] ? rf[s] : rf[13-s];
            b = pol_mem[c] ? rf[s+1] : rf[12-s];
            chk((got[c] >= (a < b ? a : b)) && (got[c] <= (a < b ? b : a)) && lo == 0,
                "R9 bounded", got[c], a);
        end
    endtask

    initial begin
        load_refs(0);
        for (int c = 0; c < NCOL; c++) begin code_mem[c] = '0; pol_mem[c] = 1'b0; end
        repeat (3) @(negedge clk);
        chk(!wr_en, "R1 wr_en in reset", int'(wr_en), 0);
        chk(!done, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en && !done, "R1 quiet after reset", int'(wr_en) + int'(done), 0);
        chk(rd_addr == '0, "R1 rd_addr after reset", int'(rd_addr), 0);
        run_pass(0);
        run_pass(1);
        run_pass(2);
        load_refs(1);
        run_pass(0);
        run_pass(1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule